// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block is the MAC-side transmit path of a 10/100 media-independent interface. A byte stream comes in through a valid/ready handshake. Each byte carries a first marker and a last marker. The block puts the preamble and start-of-frame delimiter in front of the data, splits every byte into two nibbles and drives the transmit enable and the 4-bit transmit data lines toward the PHY.

All logic runs on the transmit clock that the PHY supplies: 2.5 MHz at 10 Mbps and 25 MHz at 100 Mbps. Every output is a register clocked by it. The block does not add a frame check sequence and does not pad short frames. The upstream source supplies both. The block keeps a minimum idle gap between frames. If the source runs dry in the middle of a frame, the frame is cut short and a one-cycle flag reports this.

Top module: `mii_tx_framer`

## Requirements
- R1: While rst_ni is low, txen_o is 0, txd_o is 4'h0, in_ready_o is 0 and underrun_o is 0.
- R2: txer_o is 0 in every cycle.
- R3: When the block is idle and its gap is complete, a cycle with in_valid_i=1 and in_first_i=1 at a clock edge makes txen_o rise at that edge. txd_o carries the first preamble nibble 4'h5 in the same cycle.
- R4: Each frame starts with 15 nibbles of 4'h5 and then one nibble of 4'hD, all with txen_o high.
- R5: Each accepted byte is sent as two nibbles on consecutive cycles: bits [3:0] first, then bits [7:4]. txen_o stays high from the first preamble nibble to the last data nibble.
- R6: in_ready_o is high only in a cycle where txen_o is high and txd_o holds the delimiter or the upper nibble of a byte that was not marked last. It is always high in the delimiter cycle. So at most one byte is taken every two cycles.
- R7: A frame whose last byte is flagged with in_last_i sends exactly 16 + 2·N nibbles for N bytes. txen_o falls at the edge right after that byte's upper nibble.
- R8: Whenever txen_o is low, txd_o is 4'h0.
- R9: If in_valid_i is low in a cycle where in_ready_o is high, the frame ends: txen_o falls at the next edge. underrun_o is high for exactly that first low cycle, and is low at all other times.
- R10: Between two frames txen_o stays low for at least 24 cycles. If a new start request is already waiting, the next frame begins after exactly 24 low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock from the PHY |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Byte on in_data_i is valid |
| in_first_i | input | 1 | Byte is the first of a frame |
| in_last_i | input | 1 | Byte is the last of a frame |
| in_ready_o | output | 1 | Byte is taken at this edge if valid |
| txen_o | output | 1 | Transmit enable toward the PHY |
| txd_o | output | 4 | Transmit nibble toward the PHY |
| txer_o | output | 1 | Transmit error, held low |
| underrun_o | output | 1 | One-cycle flag: frame cut short for lack of data |

## Verification
The end of the inter-frame gap and a new start request can land in the same cycle. That happens whenever the source holds valid and first high through the whole tail of the previous frame. The bench provokes this with back-to-back frames, both after normal frames and after truncated ones. It measures the low run of txen_o, which must be exactly 24, and checks that the new frame's preamble is intact. A second overlap is an underrun at the delimiter load point. In that case the frame must shrink to preamble plus delimiter and the flag must coincide with the falling enable.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] NIB_PRE  = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SFD  = 4'hD;
  localparam logic [NIB_W-1:0] NIB_IDLE = 4'h0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_GAP
  } tx_state_e;

  // what the wire carries in the next cycle
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_PRE,
    CMD_SFD,
    CMD_LO,
    CMD_HI
  } nib_cmd_e;
endpackage

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int unsigned PRE_NIBBLES = 15,
  parameter int unsigned GAP_NIBBLES = 24
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  logic     first_i,
  input  logic     last_i,
  output logic     ready_o,
  output nib_cmd_e cmd_o,
  output logic     idle_o,
  output logic     underrun_o
);
  localparam int unsigned CNT_MAX = (PRE_NIBBLES > GAP_NIBBLES) ? PRE_NIBBLES : GAP_NIBBLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PRE_C = CNT_W'(PRE_NIBBLES);
  localparam logic [CNT_W-1:0] GAP_C = CNT_W'(GAP_NIBBLES);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d;     // wire holds SFD or an upper nibble
  logic             last_q, last_d; // byte on the wire is the final one
  logic             und_q, und_d;
  logic             start_req;

  assign start_req = valid_i & first_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    last_d = last_q;
    und_d  = 1'b0;
    cmd_o  = CMD_IDLE;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          cmd_o  = CMD_PRE;
          st_d   = ST_PRE;
          cnt_d  = ONE_C;
          last_d = 1'b0;
        end
      end
      ST_PRE: begin
        if (cnt_q < PRE_C) begin
          cmd_o = CMD_PRE;
          cnt_d = cnt_q + ONE_C;
        end else begin
          cmd_o = CMD_SFD;
          st_d  = ST_DATA;
          hi_d  = 1'b1;
        end
      end
      ST_DATA: begin
        if (!hi_q) begin
          cmd_o = CMD_HI;
          hi_d  = 1'b1;
        end else if (last_q) begin
          st_d  = ST_GAP;
          cnt_d = ONE_C;
        end else if (valid_i) begin
          cmd_o  = CMD_LO;
          hi_d   = 1'b0;
          last_d = last_i;
        end else begin
          und_d = 1'b1;
          st_d  = ST_GAP;
          cnt_d = ONE_C;
        end
      end
      ST_GAP: begin
        if (cnt_q != GAP_C) begin
          cnt_d = cnt_q + ONE_C;
        end else if (start_req) begin
          cmd_o  = CMD_PRE;
          st_d   = ST_PRE;
          cnt_d  = ONE_C;
          last_d = 1'b0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hi_q   <= 1'b0;
      last_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
      last_q <= last_d;
      und_q  <= und_d;
    end
  end

  assign ready_o    = (st_q == ST_DATA) & hi_q & ~last_q;
  assign idle_o     = (st_q == ST_IDLE);
  assign underrun_o = und_q;

  // preamble counter never leaves its range
  assert_pre_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE) |-> (cnt_q >= ONE_C && cnt_q <= PRE_C));

  // a cut frame always lands in the gap state
  assert_underrun_to_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_q |-> (st_q == ST_GAP && cnt_q == ONE_C));
endmodule

// File: rtl/mii_tx_nibbler.sv
module mii_tx_nibbler
  import mii_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  nib_cmd_e          cmd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              txen_o,
  output logic [NIB_W-1:0]  txd_o
);
  logic             txen_q, txen_d;
  logic [NIB_W-1:0] txd_q, txd_d;
  logic [NIB_W-1:0] upper_q, upper_d;

  always_comb begin
    txen_d  = 1'b1;
    txd_d   = NIB_IDLE;
    upper_d = upper_q;
    unique case (cmd_i)
      CMD_PRE: txd_d = NIB_PRE;
      CMD_SFD: txd_d = NIB_SFD;
      CMD_LO: begin
        txd_d   = byte_i[NIB_W-1:0];
        upper_d = byte_i[BYTE_W-1:NIB_W];
      end
      CMD_HI:  txd_d = upper_q;
      default: txen_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txen_q  <= 1'b0;
      txd_q   <= NIB_IDLE;
      upper_q <= NIB_IDLE;
    end else begin
      txen_q  <= txen_d;
      txd_q   <= txd_d;
      upper_q <= upper_d;
    end
  end

  assign txen_o = txen_q;
  assign txd_o  = txd_q;

  // an upper nibble is only ever sent right after its lower half
  assert_hi_follows_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_HI) |-> txen_q);
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
#(
  parameter int unsigned PRE_NIBBLES = 15,
  parameter int unsigned GAP_NIBBLES = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_first_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic       txen_o,
  output logic [3:0] txd_o,
  output logic       txer_o,
  output logic       underrun_o
);
  localparam int unsigned RUN_W = $clog2(GAP_NIBBLES + 2);
  localparam logic [RUN_W-1:0] GAP_R = RUN_W'(GAP_NIBBLES);

  nib_cmd_e cmd;
  logic     ctrl_idle;

  mii_tx_ctrl #(
    .PRE_NIBBLES(PRE_NIBBLES),
    .GAP_NIBBLES(GAP_NIBBLES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (in_valid_i),
    .first_i   (in_first_i),
    .last_i    (in_last_i),
    .ready_o   (in_ready_o),
    .cmd_o     (cmd),
    .idle_o    (ctrl_idle),
    .underrun_o(underrun_o)
  );

  mii_tx_nibbler u_nib (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .byte_i(in_data_i),
    .txen_o(txen_o),
    .txd_o (txd_o)
  );

  assign txer_o = 1'b0;

  // assertion-side low-run tracker
  logic [RUN_W-1:0] low_run_q;
  logic             txen_prev_q;
  logic             seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q   <= '0;
      txen_prev_q <= 1'b0;
      seen_q      <= 1'b0;
    end else begin
      txen_prev_q <= txen_o;
      if (txen_o) begin
        low_run_q <= '0;
        seen_q    <= 1'b1;
      end else if (low_run_q <= GAP_R) begin
        low_run_q <= low_run_q + RUN_W'(1);
      end
    end
  end

  assert_txd_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txen_o |-> (txd_o == NIB_IDLE));

  assert_start_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_idle && in_valid_i && in_first_i) |=> (txen_o && txd_o == NIB_PRE));

  assert_ready_in_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> txen_o);

  assert_underrun_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (!txen_o && txen_prev_q));

  assert_gap_min_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txen_o && !txen_prev_q && seen_q) |-> (low_run_q >= GAP_R));
endmodule

// File: tb/mii_tx_framer_tb.sv
module mii_tx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic       in_ready, txen, txer, underrun;
  logic [3:0] txd;

  always #5 clk = ~clk;

  mii_tx_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_first_i(in_first), .in_last_i(in_last), .in_ready_o(in_ready),
    .txen_o(txen), .txd_o(txd), .txer_o(txer), .underrun_o(underrun)
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_data [0:63][0:39];
  int  exp_len [0:63];
  bit  exp_und [0:63];
  bit  exp_b2b [0:63];
  int  fi = 0, rx_idx = 0;
  bit  done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_nibbles(int nbytes);
    return 16 + 2 * nbytes;
  endfunction

  // monitor
  bit mon_en = 0;
  bit prev_txen = 0;
  int nib [0:127];
  int n = 0, low_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!txen && txd == 4'h0 && !in_ready && !underrun, "R1",
          {txen, txd, in_ready, underrun}, 0);
    end else if (mon_en) begin
      chk(txer == 1'b0, "R2", txer, 0);
      if (txen) begin
        if (!prev_txen) begin
          if (rx_idx > 0) chk(low_cnt >= 24, "R10", low_cnt, 24);
          if (exp_b2b[rx_idx]) chk(low_cnt == 24, "R10", low_cnt, 24);
          n = 0;
        end
        if (n < 128) nib[n] = int'(txd);
        n++;
        if (in_ready) chk(n >= 16 && (n % 2) == 0, "R6", n, 16);
        if (n == 16) chk(in_ready, "R6", in_ready, 1);
        chk(!underrun, "R9", underrun, 0);
      end else begin
        chk(txd == 4'h0, "R8", txd, 0);
        chk(!in_ready, "R6", in_ready, 0);
        if (prev_txen) begin
          int len;
          len = exp_len[rx_idx];
          chk(n == exp_nibbles(len), "R7", n, exp_nibbles(len));
          for (int p = 0; p < 15; p++) chk(nib[p] == 5, "R4", nib[p], 5);
          chk(nib[15] == 13, "R4", nib[15], 13);
          for (int i = 0; i < len; i++)
            if (2 * i + 17 < n)
              chk({nib[2*i+17][3:0], nib[2*i+16][3:0]} == exp_data[rx_idx][i], "R5",
                  {nib[2*i+17][3:0], nib[2*i+16][3:0]}, exp_data[rx_idx][i]);
          chk(underrun == exp_und[rx_idx], "R9", underrun, exp_und[rx_idx]);
          rx_idx++;
          low_cnt = 1;
        end else begin
          chk(!underrun, "R9", underrun, 0);
          low_cnt++;
        end
      end
      prev_txen = txen;
    end
  end

  // und_k < 0: normal frame; otherwise cut after und_k bytes
  task automatic send_frame(int len, int und_k, int dly);
    int nsend;
    nsend = (und_k >= 0) ? und_k : len;
    repeat (dly) @(negedge clk);
    exp_len[fi] = nsend;
    exp_und[fi] = (und_k >= 0);
    exp_b2b[fi] = (dly == 0) && (fi > 0);
    for (int i = 0; i < len; i++) exp_data[fi][i] = 8'($urandom);
    in_valid = 1'b1;
    in_first = 1'b1;
    in_data  = (nsend > 0) ? exp_data[fi][0] : 8'hA7;
    in_last  = (und_k < 0) && (len == 1);
    if (dly > 0) begin
      @(negedge clk);
      chk(txen && txd == 4'h5, "R3", {txen, txd}, 5'h15);
    end
    if (nsend == 0) in_valid = 1'b0;
    for (int i = 0; i < nsend; i++) begin
      in_data  = exp_data[fi][i];
      in_first = (i == 0);
      in_last  = (und_k < 0) && (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    fi++;
    if (und_k >= 0) while (txen) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    // directed corners
    send_frame(1, -1, 3);
    send_frame(3, -1, 0);   // gap expiry meets pending start
    send_frame(4, 0, 35);   // underrun at delimiter point
    send_frame(5, 3, 32);   // underrun mid-frame
    send_frame(2, -1, 0);   // back-to-back after cut frame
    for (int f = 0; f < 30; f++) begin
      int len, und, dly;
      len = 1 + int'($urandom % 40);
      und = (($urandom % 6) == 0) ? int'($urandom % len) : -1;
      dly = (($urandom % 2) == 0 && und < 0) ? 0 : 30 + int'($urandom % 16);
      send_frame(len, und, dly);
    end
    repeat (60) @(negedge clk);
    chk(rx_idx == fi, "R7", rx_idx, fi);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual %0d frames expected %0d", rx_idx, fi);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule